// File: doc/BRIEF.md
# Sliding-Window Tap Router

This block takes a grayscale raster image as a continuous stream, one pixel on every clock, and keeps a 3×3 neighbourhood whose bottom-right corner is the pixel that has just arrived. It feeds several edge inputs of a processing array, one tap per input. Each tap delivers one pixel of the neighbourhood, chosen by a small per-tap configuration.

Each tap chooses in two steps. First it picks one of the three window rows. Then it delays that row's pixel by zero, one or two clocks. Because the window moves one column right on every clock, a delay of k gives the pixel k columns to the left, so no nine-way multiplexer is needed.

The raw window travels along a chain of registers, one register per tap. Tap j therefore delivers its pixel exactly one clock after tap j−1. An array whose internal paths also add one clock per hop sees the same latency on every route. Two line buffers, each one image row deep, hold the two rows above the current one. At the left image edge, a column that would fall outside the image is replaced by column 0. The first two rows of each frame, plus two pixels, are flagged as not valid.

Top module: `nts_window_router`

## Requirements
- R1: While reset is asserted, every tap output and every tap valid flag is 0.
- R2: The first pixel accepted after reset is row 0, column 0 of a frame of IMG_W×IMG_H pixels in raster order. Frames follow each other with no gap, and the row and column positions wrap at the frame end.
- R3: For the window whose newest pixel sits at frame position f (f = row·IMG_W + column), the valid flag is 0 when f < 2·IMG_W+2 and 1 otherwise.
- R4: Row code 0 selects the row of the newest pixel, code 1 the row above it and code 2 two rows above. Code 3 behaves as code 2.
- R5: Column code k selects the pixel k columns left of the newest pixel, for k from 0 to 2. Code 3 behaves as code 2.
- R6: When the newest pixel's column c is less than the column code k, column 0 of the selected row is delivered instead.
- R7: The window whose newest pixel is accepted at clock edge e appears on tap j after edge e+j+2.
- R8: A write with cfg_we_i high loads cfg_row_i and cfg_col_i into the tap numbered cfg_idx_i and changes no other tap. A write with an index of N_TAPS or more changes no tap.
- R9: tap_valid_o[j] is the R3 flag of the window currently on tap j, so it trails tap_valid_o[j-1] by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | PIX_W | Pixel accepted on every clock |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Tap number for the write |
| cfg_row_i | input | 2 | Row code (0 newest row, 1 above, 2 two above, 3 as 2) |
| cfg_col_i | input | 2 | Column code (columns left of newest, 3 as 2) |
| tap_o | output | N_TAPS·PIX_W | Tap pixels, tap j in bits [j·PIX_W +: PIX_W] |
| tap_valid_o | output | N_TAPS | Valid flag per tap |

## Verification
A wrong row or column counter shows up at once, because the valid flag starts too early or too late and the left-edge clamp fires on the wrong pixels. A line buffer written or read at the wrong address gives a wrong value on any tap with a row code other than 0, once a full row has gone by. A missing or extra register in the chain or in a selector moves tap j by one pixel, and every valid window on that tap shows it within j+2 clocks. Configuration faults appear as a wrong row or column on one tap only, or as a change on a tap that was not addressed.

// File: rtl/nts_pkg.sv
package nts_pkg;

    typedef logic [1:0] sel_code_t;

    typedef struct packed {
        sel_code_t row;
        sel_code_t col;
    } tap_cfg_t;

    // code 3 is folded onto code 2 for both row and column selection
    function automatic sel_code_t code_norm(input sel_code_t c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction

endpackage

// File: rtl/nts_linebuf.sv
module nts_linebuf #(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    parameter int PIX_W = 8,
    parameter int COL_W = $clog2(IMG_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PIX_W-1:0]            pix_i,
    output logic [2:0][PIX_W-1:0]       rows_o,
    output logic [COL_W-1:0]            col_o,
    output logic                        valid_o
);
    localparam int ROW_W = $clog2(IMG_H);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);

    typedef struct packed {
        logic [COL_W-1:0]      col;
        logic [ROW_W-1:0]      row;
        logic [2:0][PIX_W-1:0] rows;
        logic [COL_W-1:0]      col_out;
        logic                  valid;
    } lb_state_t;

    lb_state_t s_d, s_q;

    // one image row of the previous line and one of the line before it
    logic [PIX_W-1:0] lb1_q [IMG_W];
    logic [PIX_W-1:0] lb2_q [IMG_W];

    always_comb begin
        s_d         = s_q;
        s_d.rows[0] = pix_i;
        s_d.rows[1] = lb1_q[s_q.col];
        s_d.rows[2] = lb2_q[s_q.col];
        s_d.col_out = s_q.col;
        s_d.valid   = (s_q.row > ROW_W'(2)) ||
                      ((s_q.row == ROW_W'(2)) && (s_q.col >= COL_W'(2)));
        if (s_q.col == LAST_COL) begin
            s_d.col = '0;
            s_d.row = (s_q.row == LAST_ROW) ? '0 : s_q.row + ROW_W'(1);
        end else begin
            s_d.col = s_q.col + COL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        lb1_q[s_q.col] <= pix_i;
        lb2_q[s_q.col] <= lb1_q[s_q.col];
    end

    assign rows_o  = s_q.rows;
    assign col_o   = s_q.col_out;
    assign valid_o = s_q.valid;

    a_r2_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.col == LAST_COL) |=> (s_q.col == '0));

    a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.col == LAST_COL) && (s_q.row != LAST_ROW)) |=> (s_q.row == $past(s_q.row) + ROW_W'(1)));

    a_r3_valid_rows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((s_q.row >= ROW_W'(2)) || ((s_q.row == '0) && (s_q.col == '0))));

endmodule

// File: rtl/nts_cfg_bank.sv
module nts_cfg_bank #(
    parameter int N_TAPS = 8,
    parameter int IDX_W  = $clog2(N_TAPS) + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  nts_pkg::sel_code_t                row_i,
    input  nts_pkg::sel_code_t                col_i,
    output nts_pkg::tap_cfg_t [N_TAPS-1:0]    cfg_o
);
    import nts_pkg::*;

    tap_cfg_t [N_TAPS-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < N_TAPS; i++) begin
            if (we_i && (idx_i == IDX_W'(i))) begin
                cfg_d[i].row = row_i;
                cfg_d[i].col = col_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    for (genvar i = 0; i < N_TAPS; i++) begin : g_chk
        a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && (idx_i == IDX_W'(i))) |=>
                ((cfg_q[i].row == $past(row_i)) && (cfg_q[i].col == $past(col_i))));

        a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (idx_i == IDX_W'(i))) |=> $stable(cfg_q[i]));
    end

endmodule

// File: rtl/nts_tap_sel.sv
module nts_tap_sel #(
    parameter int PIX_W = 8,
    parameter int COL_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0][PIX_W-1:0]    rows_i,
    input  logic [COL_W-1:0]         col_i,
    input  logic                     valid_i,
    input  nts_pkg::tap_cfg_t        cfg_i,
    output logic [PIX_W-1:0]         tap_o,
    output logic                     valid_o
);
    import nts_pkg::*;

    typedef struct packed {
        logic [PIX_W-1:0] sel;
        logic [PIX_W-1:0] h1;
        logic [PIX_W-1:0] h2;
        logic [COL_W-1:0] col_s;
        logic             vs;
        logic [PIX_W-1:0] tap;
        logic             vt;
    } sel_state_t;

    sel_state_t s_d, s_q;
    sel_code_t  rc, kc, m;

    always_comb begin
        rc = code_norm(cfg_i.row);
        kc = code_norm(cfg_i.col);
        // effective delay never reaches past column 0 of the current row
        if (s_q.col_s < COL_W'(kc)) m = s_q.col_s[1:0];
        else                        m = kc;

        s_d       = s_q;
        s_d.sel   = rows_i[rc];
        s_d.col_s = col_i;
        s_d.vs    = valid_i;
        s_d.h1    = s_q.sel;
        s_d.h2    = s_q.h1;
        s_d.vt    = s_q.vs;
        case (m)
            2'd0:    s_d.tap = s_q.sel;
            2'd1:    s_d.tap = s_q.h1;
            default: s_d.tap = s_q.h2;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tap_o   = s_q.tap;
    assign valid_o = s_q.vt;

    a_r6_left_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.col_s == '0) |=> (tap_o == $past(s_q.sel)));

    a_r5_code3_as_2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_i.col == 2'd3) && (s_q.col_s >= COL_W'(2))) |=> (tap_o == $past(s_q.h2)));

endmodule

// File: rtl/nts_window_router.sv
module nts_window_router #(
    parameter int IMG_W  = 128,
    parameter int IMG_H  = 128,
    parameter int PIX_W  = 8,
    parameter int N_TAPS = 8,
    parameter int IDX_W  = $clog2(N_TAPS) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PIX_W-1:0]           pix_i,
    input  logic                       cfg_we_i,
    input  logic [IDX_W-1:0]           cfg_idx_i,
    input  logic [1:0]                 cfg_row_i,
    input  logic [1:0]                 cfg_col_i,
    output logic [N_TAPS*PIX_W-1:0]    tap_o,
    output logic [N_TAPS-1:0]          tap_valid_o
);
    import nts_pkg::*;

    localparam int COL_W = $clog2(IMG_W);

    typedef struct packed {
        logic [2:0][PIX_W-1:0] rows;
        logic [COL_W-1:0]      col;
        logic                  valid;
    } link_t;

    logic [2:0][PIX_W-1:0]  lb_rows;
    logic [COL_W-1:0]       lb_col;
    logic                   lb_valid;
    tap_cfg_t [N_TAPS-1:0]  cfg_w;

    link_t [N_TAPS-1:0] lk;
    link_t [N_TAPS-2:0] chain_d, chain_q;

    nts_linebuf #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .PIX_W (PIX_W),
        .COL_W (COL_W)
    ) u_lb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_i   (pix_i),
        .rows_o  (lb_rows),
        .col_o   (lb_col),
        .valid_o (lb_valid)
    );

    nts_cfg_bank #(
        .N_TAPS (N_TAPS),
        .IDX_W  (IDX_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (cfg_we_i),
        .idx_i (cfg_idx_i),
        .row_i (cfg_row_i),
        .col_i (cfg_col_i),
        .cfg_o (cfg_w)
    );

    // window chain: one register per tap so tap j sees the window j clocks late
    always_comb begin
        lk[0].rows  = lb_rows;
        lk[0].col   = lb_col;
        lk[0].valid = lb_valid;
        for (int j = 1; j < N_TAPS; j++) lk[j] = chain_q[j-1];
        for (int j = 0; j < N_TAPS - 1; j++) chain_d[j] = lk[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    for (genvar j = 0; j < N_TAPS; j++) begin : g_tap
        nts_tap_sel #(
            .PIX_W (PIX_W),
            .COL_W (COL_W)
        ) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .rows_i  (lk[j].rows),
            .col_i   (lk[j].col),
            .valid_i (lk[j].valid),
            .cfg_i   (cfg_w[j]),
            .tap_o   (tap_o[j*PIX_W +: PIX_W]),
            .valid_o (tap_valid_o[j])
        );
    end

    for (genvar j = 0; j < N_TAPS - 1; j++) begin : g_chk
        a_r9_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
            tap_valid_o[j+1] == $past(tap_valid_o[j]));
    end

endmodule

// File: tb/tb_nts_window_router.sv
module tb_nts_window_router;
    localparam int W  = 8;
    localparam int H  = 6;
    localparam int N  = 4;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     pix_i = '0;
    logic           cfg_we_i = 1'b0;
    logic [IW-1:0]  cfg_idx_i = '0;
    logic [1:0]     cfg_row_i = '0;
    logic [1:0]     cfg_col_i = '0;
    logic [N*8-1:0] tap_o;
    logic [N-1:0]   tap_valid_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  edges = 0;
    bit  run = 1'b0;
    bit  done = 1'b0;
    logic [7:0] drv [0:8191];
    int  mrow [N];
    int  mcol [N];

    always #2 clk = ~clk;

    nts_window_router #(
        .IMG_W (W), .IMG_H (H), .PIX_W (8), .N_TAPS (N), .IDX_W (IW)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pix_i (pix_i),
        .cfg_we_i (cfg_we_i), .cfg_idx_i (cfg_idx_i),
        .cfg_row_i (cfg_row_i), .cfg_col_i (cfg_col_i),
        .tap_o (tap_o), .tap_valid_o (tap_valid_o)
    );

    function automatic logic [7:0] gen(input int n);
        int v;
        v = n * 37 + (n / W) * 13 + 11;
        return v[7:0];
    endfunction

    function automatic int nrm(input int c);
        return (c == 3) ? 2 : c;
    endfunction

    // pixel stream: one new pixel ahead of every clock edge
    initial begin
        wait (run);
        forever begin
            pix_i = gen(edges);
            drv[edges] = pix_i;
            @(posedge clk);
            edges = edges + 1;
            @(negedge clk);
        end
    end

    task automatic chk(input bit ok, input string tag, input int j, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s tap %0d got %0d expected %0d (edge %0d)", tag, j, got, exp, edges);
        end
    endtask

    task automatic run_checks(input string vtag, input int ncyc);
        repeat (ncyc) begin
            @(negedge clk);
            for (int j = 0; j < N; j++) begin
                int q, f, c, m, rc, kc, ev, ex;
                q  = edges - 1 - j - 2;
                rc = nrm(mrow[j]);
                kc = nrm(mcol[j]);
                ev = 0;
                if (q >= 0) begin
                    f  = q % (W * H);
                    ev = (f >= 2 * W + 2) ? 1 : 0;
                end
                chk(tap_valid_o[j] == ev[0], (j == 0) ? "R3" : "R9", j, int'(tap_valid_o[j]), ev);
                if (ev != 0) begin
                    c  = f % W;
                    m  = (kc > c) ? c : kc;
                    ex = int'(drv[q - rc * W - m]);
                    chk(int'(tap_o[j*8 +: 8]) == ex, (kc > c) ? "R6" : vtag, j,
                        int'(tap_o[j*8 +: 8]), ex);
                end
            end
        end
    endtask

    task automatic cfg_write(input int idx, input int row, input int col);
        @(negedge clk);
        cfg_we_i  = 1'b1;
        cfg_idx_i = IW'(idx);
        cfg_row_i = 2'(row);
        cfg_col_i = 2'(col);
        @(negedge clk);
        cfg_we_i = 1'b0;
        if (idx < N) begin
            mrow[idx] = row;
            mcol[idx] = col;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        for (int j = 0; j < N; j++) begin
            chk(tap_valid_o[j] == 1'b0, "R1", j, int'(tap_valid_o[j]), 0);
            chk(tap_o[j*8 +: 8] == 8'd0, "R1", j, int'(tap_o[j*8 +: 8]), 0);
        end
        rst_n = 1'b1;
        run   = 1'b1;
    endtask

    task automatic t_default;
        run_checks("R7", 70);
    endtask

    task automatic t_rows;
        for (int j = 0; j < N; j++) cfg_write(j, j, 0);
        run_checks("R4", 50);
    endtask

    task automatic t_cols;
        for (int j = 0; j < N; j++) cfg_write(j, 1, j);
        run_checks("R5", 50);
    endtask

    task automatic t_mixed;
        cfg_write(0, 2, 2);
        cfg_write(1, 3, 1);
        cfg_write(2, 0, 3);
        cfg_write(3, 1, 2);
        run_checks("R2", 110);
    endtask

    task automatic t_bad_index;
        cfg_write(N, 0, 0);
        cfg_write(7, 3, 3);
        run_checks("R8", 30);
        cfg_write(2, 1, 1);
        run_checks("R8", 30);
    endtask

    initial begin
        for (int j = 0; j < N; j++) begin
            mrow[j] = 0;
            mcol[j] = 0;
        end
        t_reset();
        t_default();
        t_rows();
        t_cols();
        t_mixed();
        t_bad_index();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule